// File: doc/BRIEF.md
# SMBus Register Access Slave

This block is a two-wire serial bus target that gives an external bus master byte-wide access to a bank of up to 32 eight-bit registers. The bank itself lives outside the block. The block watches the clock and data lines through synchronizers. It pulls the data line low through an open-drain enable. Toward the inside it issues a one-cycle write strobe with a register index and a data byte. It also presents a read index and takes the addressed byte back on a combinational read-data input.

Three transfer shapes are served. In a write, the master sends the device address with the write bit, a command byte and a data byte. In a read, the master sends the address with the write bit and a command byte, then a repeated START and the address with the read bit, and then clocks out one byte. In a receive, the master sends the address with the read bit right after START, and the block returns the register at the current pointer. The pointer is taken from the low bits of the command byte. Every STOP sets it back to zero, so a receive that follows a STOP always returns register 0.

The system clock must run at least eight times faster than the bus clock.

Top module: `smbus_reg_slave`

## Requirements
- R1: After START, the block acknowledges a 7-bit address equal to DEV_ADDR followed by the R/W bit (0 = write, 1 = read). On any other address it acknowledges nothing, issues no write and leaves SDA released until the next START or STOP.
- R2: In a write transfer, the byte after the address is a command. Its bits [4:0] become the register pointer and bits [7:5] are ignored. The next byte produces exactly one single-cycle wr_en_o pulse, with wr_addr_o equal to the pointer and wr_data_o equal to that byte.
- R3: The acknowledge for a matched address, a command byte or a write data byte holds SDA low for the whole high phase of the ninth bus clock.
- R4: In a read transfer (address+write, command, repeated START, address+read), the block returns the register selected by the command, MSB first.
- R5: Out of reset the pointer is 0, SDA is released and no write strobe is active.
- R6: A repeated START returns the block to address reception and keeps the pointer, so a second address+read after it returns the same register again.
- R7: A STOP clears the pointer to 0. A receive transfer that follows a STOP returns register 0.
- R8: The block changes its SDA pull-down only while SCL is low.
- R9: After the master declines to acknowledge a read byte, the block keeps SDA released for any further clocks until the next START or STOP.
- R10: A data bit whose SDA transition reaches the block in the same system clock as the SCL rising edge is taken as that bit. It is never taken as a START or a STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_pd_o | output | 1 | 1 = pull the data line low |
| wr_en_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | PTR_W | Register index for the write |
| wr_data_o | output | 8 | Byte to be written |
| rd_addr_o | output | PTR_W | Register index being read (the pointer) |
| rd_data_i | input | 8 | Contents of the register at rd_addr_o |

## Verification
Two functions can fall in one system clock: the SCL rising-edge sampler and the SDA transition detector that finds START and STOP. They meet when the master moves SDA with zero setup to the SCL rise. The bench provokes this by running a complete write transfer in which every data bit is driven in the same clock as SCL goes high. The result is judged at the ports: all three bytes must be acknowledged, the scoreboard must receive exactly the expected write, and a normal read must return the written value.

// File: rtl/smbus_slv_pkg.sv
package smbus_slv_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_CMD,
      ST_CMD_ACK,
      ST_WDATA,
      ST_WDATA_ACK,
      ST_RDATA,
      ST_RACK,
      ST_IGNORE
   } eng_state_e;

endpackage

// File: rtl/smbus_slv_sync.sv
module smbus_slv_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   localparam int LINES = 2;

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("SYNC_STAGES must be at least 2");
   end

   logic [LINES-1:0] pins;
   logic [LINES-1:0] synced;
   logic             scl_q;
   logic             sda_q;

   assign pins = {scl_i, sda_i};

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '1;
         else        chain <= {chain[SYNC_STAGES-2:0], pins[g]};
      end
      assign synced[g] = chain[SYNC_STAGES-1];
   end

   assign scl_s = synced[1];
   assign sda_s = synced[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   // SCL must be high in both cycles, so an SDA move that lands with the rise is data
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

   // R10
   edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scl_rise |-> !(start_det || stop_det));

endmodule

// File: rtl/smbus_slv_engine.sv
module smbus_slv_engine
   import smbus_slv_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h2C,
   parameter int         PTR_W    = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_s,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [BYTE_W-1:0] rd_data,
   output logic              sda_pd,
   output logic              wr_en,
   output logic [PTR_W-1:0]  wr_addr,
   output logic [BYTE_W-1:0] wr_data,
   output logic [PTR_W-1:0]  ptr
);

   localparam int CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

   if (PTR_W < 1 || PTR_W > BYTE_W) begin : g_bad_ptr
      $error("PTR_W must lie between 1 and 8");
   end

   eng_state_e        state;
   logic [CNT_W-1:0]  cnt;
   logic [BYTE_W-1:0] shreg;
   logic              rw;
   logic              mack_n;
   logic              rx_state;

   assign rx_state = (state == ST_ADDR) || (state == ST_CMD) || (state == ST_WDATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         shreg   <= '0;
         ptr     <= '0;
         sda_pd  <= 1'b0;
         rw      <= 1'b0;
         mack_n  <= 1'b1;
         wr_en   <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
      end else begin
         wr_en <= 1'b0;
         if (stop_det) begin
            state  <= ST_IDLE;
            ptr    <= '0;
            sda_pd <= 1'b0;
            cnt    <= '0;
         end else if (start_det) begin
            state  <= ST_ADDR;
            sda_pd <= 1'b0;
            cnt    <= '0;
         end else if (rx_state) begin
            if (scl_rise) begin
               shreg <= {shreg[BYTE_W-2:0], sda_s};
               cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST_BIT) begin
               cnt <= '0;
               unique case (state)
                  ST_ADDR: begin
                     if (shreg[BYTE_W-1:1] == DEV_ADDR) begin
                        rw     <= shreg[0];
                        sda_pd <= 1'b1;
                        state  <= ST_ADDR_ACK;
                     end else begin
                        state  <= ST_IGNORE;
                     end
                  end
                  ST_CMD: begin
                     ptr    <= shreg[PTR_W-1:0];
                     sda_pd <= 1'b1;
                     state  <= ST_CMD_ACK;
                  end
                  default: begin
                     wr_en   <= 1'b1;
                     wr_addr <= ptr;
                     wr_data <= shreg;
                     sda_pd  <= 1'b1;
                     state   <= ST_WDATA_ACK;
                  end
               endcase
            end
         end else begin
            unique case (state)
               ST_ADDR_ACK: if (scl_fall) begin
                  cnt <= '0;
                  if (rw) begin
                     shreg  <= rd_data;
                     sda_pd <= ~rd_data[BYTE_W-1];
                     state  <= ST_RDATA;
                  end else begin
                     sda_pd <= 1'b0;
                     state  <= ST_CMD;
                  end
               end
               ST_CMD_ACK: if (scl_fall) begin
                  sda_pd <= 1'b0;
                  state  <= ST_WDATA;
               end
               ST_WDATA_ACK: if (scl_fall) begin
                  sda_pd <= 1'b0;
                  state  <= ST_IGNORE;
               end
               ST_RDATA: begin
                  if (scl_rise) begin
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall) begin
                     if (cnt == LAST_BIT) begin
                        sda_pd <= 1'b0;
                        cnt    <= '0;
                        state  <= ST_RACK;
                     end else begin
                        shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                        sda_pd <= ~shreg[BYTE_W-2];
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise) begin
                     mack_n <= sda_s;
                  end else if (scl_fall) begin
                     if (!mack_n) begin
                        shreg  <= rd_data;
                        sda_pd <= ~rd_data[BYTE_W-1];
                        cnt    <= '0;
                        state  <= ST_RDATA;
                     end else begin
                        state  <= ST_IGNORE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R1
   ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IGNORE) |-> (!sda_pd && !wr_en));

   // R2
   wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

   // R2
   wr_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(state == ST_WDATA));

   // R3
   ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ADDR_ACK || state == ST_CMD_ACK || state == ST_WDATA_ACK) |-> sda_pd);

   // R7
   ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (ptr == '0));

   // R8
   pd_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_pd) |-> (!scl_s || $past(start_det || stop_det)));

   // R9
   nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RACK) |-> !sda_pd);

endmodule

// File: rtl/smbus_reg_slave.sv
module smbus_reg_slave
   import smbus_slv_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h2C,
   parameter int         PTR_W       = 5,
   parameter int         SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_pd_o,
   output logic              wr_en_o,
   output logic [PTR_W-1:0]  wr_addr_o,
   output logic [7:0]        wr_data_o,
   output logic [PTR_W-1:0]  rd_addr_o,
   input  logic [7:0]        rd_data_i
);

   if (BYTE_W != 8) begin : g_bad_byte
      $error("byte width must be 8");
   end

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

   smbus_slv_sync #(
      .SYNC_STAGES(SYNC_STAGES)
   ) i_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   smbus_slv_engine #(
      .DEV_ADDR (DEV_ADDR),
      .PTR_W    (PTR_W)
   ) i_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .rd_data   (rd_data_i),
      .sda_pd    (sda_pd_o),
      .wr_en     (wr_en_o),
      .wr_addr   (wr_addr_o),
      .wr_data   (wr_data_o),
      .ptr       (rd_addr_o)
   );

endmodule

// File: tb/test_smbus_reg_slave.sv
`timescale 1ns/1ps
module test_smbus_reg_slave;

   localparam logic [6:0] DEV = 7'h2C;
   localparam int H = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_line;
   logic sda_pd_o, wr_en_o;
   logic [4:0] wr_addr_o, rd_addr_o;
   logic [7:0] wr_data_o, rd_data_i;
   logic [7:0] bank [32];
   logic [7:0] exp_bank [32];
   logic [12:0] exp_q [$];
   int n_chk = 0, n_fail = 0, pd_bad = 0;
   logic pd_q = 1'b0;

   always #2.5 clk = ~clk;

   assign sda_line  = sda_m & ~sda_pd_o;
   assign rd_data_i = bank[rd_addr_o];

   smbus_reg_slave #(.DEV_ADDR(DEV)) i_smbus_reg_slave (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_pd_o(sda_pd_o), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o),
      .wr_data_o(wr_data_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 32; i++) bank[i] <= 8'(i * 7 + 3);
      end else if (wr_en_o) begin
         bank[wr_addr_o] <= wr_data_o;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // scoreboard monitor: every write strobe pops one expected {addr,data}
   always @(negedge clk) begin
      if (rst_n && wr_en_o) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R1/R2 unexpected write", {wr_addr_o, wr_data_o}, 0);
         end else begin
            automatic logic [12:0] e = exp_q.pop_front();
            check({wr_addr_o, wr_data_o} == e, "R2 write strobe", {wr_addr_o, wr_data_o}, e);
         end
      end
   end

   // R8: pull-down may only change while the SCL pin is low
   always @(negedge clk) begin
      if (rst_n && sda_pd_o != pd_q && scl_m) pd_bad++;
      pd_q <= sda_pd_o;
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      tick(H/2); sda_m = 1'b1; tick(H/2); scl_m = 1'b1;
      tick(H); sda_m = 1'b0; tick(H); scl_m = 1'b0;
   endtask

   task automatic bus_stop();
      tick(H/2); sda_m = 1'b0; tick(H/2); scl_m = 1'b1;
      tick(H); sda_m = 1'b1; tick(H);
   endtask

   task automatic send_byte(input logic [7:0] b, input bit zs, output bit acked);
      for (int i = 7; i >= 0; i--) begin
         if (zs) begin
            tick(H); scl_m = 1'b1; sda_m = b[i];
         end else begin
            tick(H/2); sda_m = b[i]; tick(H/2); scl_m = 1'b1;
         end
         tick(H); scl_m = 1'b0;
      end
      tick(H/2); sda_m = 1'b1; tick(H/2); scl_m = 1'b1;
      acked = 1'b1;
      repeat (H) begin
         tick(1);
         if (sda_line) acked = 1'b0;
      end
      scl_m = 1'b0;
   endtask

   task automatic recv_byte(input bit nack, output logic [7:0] b);
      b = '0;
      for (int i = 0; i < 8; i++) begin
         tick(H/2); sda_m = 1'b1; tick(H/2); scl_m = 1'b1;
         tick(H/2); b = {b[6:0], sda_line}; tick(H/2); scl_m = 1'b0;
      end
      tick(H/2); sda_m = nack; tick(H/2); scl_m = 1'b1; tick(H); scl_m = 1'b0;
   endtask

   task automatic wr_xfer(input logic [7:0] cmd, input logic [7:0] data, input bit zs, input string req);
      bit a;
      exp_q.push_back({cmd[4:0], data});
      exp_bank[cmd[4:0]] = data;
      bus_start();
      send_byte({DEV, 1'b0}, zs, a); check(a, {req, " R1 R3 address ack"}, a, 1);
      send_byte(cmd, zs, a);         check(a, {req, " R3 command ack"}, a, 1);
      send_byte(data, zs, a);        check(a, {req, " R3 data ack"}, a, 1);
      bus_stop();
   endtask

   task automatic rd_xfer(input logic [7:0] cmd, input string req);
      bit a;
      logic [7:0] v;
      bus_start();
      send_byte({DEV, 1'b0}, 1'b0, a);
      send_byte(cmd, 1'b0, a);
      bus_start();
      send_byte({DEV, 1'b1}, 1'b0, a); check(a, {req, " R1 read address ack"}, a, 1);
      recv_byte(1'b1, v);
      check(v == exp_bank[cmd[4:0]], req, v, exp_bank[cmd[4:0]]);
      bus_stop();
   endtask

   task automatic rx_xfer(input string req);
      bit a;
      logic [7:0] v;
      bus_start();
      send_byte({DEV, 1'b1}, 1'b0, a); check(a, {req, " R1 ack"}, a, 1);
      recv_byte(1'b1, v);
      check(v == exp_bank[0], req, v, exp_bank[0]);
      bus_stop();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      bit a;
      logic [7:0] v;
      for (int i = 0; i < 32; i++) exp_bank[i] = 8'(i * 7 + 3);
      tick(4); rst_n = 1'b1; tick(4);

      // R5 reset state
      check(sda_pd_o == 1'b0, "R5 sda released", sda_pd_o, 0);
      check(wr_en_o == 1'b0, "R5 no strobe", wr_en_o, 0);
      check(rd_addr_o == 5'd0, "R5 pointer zero", rd_addr_o, 0);
      rx_xfer("R5 receive after reset");

      // R2 writes, upper command bits ignored
      wr_xfer(8'h03, 8'hA5, 1'b0, "R2 w3");
      wr_xfer(8'hE7, 8'h3C, 1'b0, "R2 w7 upper bits");
      wr_xfer(8'h1F, 8'h81, 1'b0, "R2 w31");
      check(exp_q.size() == 0, "R2 all writes seen", exp_q.size(), 0);

      // R4 read-byte
      rd_xfer(8'h07, "R4 read reg7");
      rd_xfer(8'hFF, "R4 read reg31 via masked command");

      // R7 STOP clears pointer
      wr_xfer(8'h00, 8'h5A, 1'b0, "R7 w0");
      rd_xfer(8'h03, "R4 read reg3");
      rx_xfer("R7 receive after stop");

      // R6 repeated START keeps pointer
      bus_start();
      send_byte({DEV, 1'b0}, 1'b0, a);
      send_byte(8'h03, 1'b0, a);
      bus_start();
      send_byte({DEV, 1'b1}, 1'b0, a);
      recv_byte(1'b1, v);
      check(v == exp_bank[3], "R6 first read", v, exp_bank[3]);
      bus_start();
      send_byte({DEV, 1'b1}, 1'b0, a);
      check(a, "R6 re-addressed ack", a, 1);
      recv_byte(1'b1, v);
      check(v == exp_bank[3], "R6 pointer kept", v, exp_bank[3]);
      // R9 further clocks after NACK read all ones
      recv_byte(1'b1, v);
      check(v == 8'hFF, "R9 released after nack", v, 8'hFF);
      bus_stop();

      // R1 address mismatch
      bus_start();
      send_byte({DEV ^ 7'h01, 1'b0}, 1'b0, a); check(!a, "R1 mismatch no ack", a, 0);
      send_byte(8'h04, 1'b0, a);               check(!a, "R1 cmd ignored", a, 0);
      send_byte(8'h99, 1'b0, a);               check(!a, "R1 data ignored", a, 0);
      bus_stop();
      rd_xfer(8'h04, "R1 reg4 unchanged");

      // R10 zero-setup bits
      wr_xfer(8'h0A, 8'h6B, 1'b1, "R10 zero setup");
      rd_xfer(8'h0A, "R10 readback");
      check(exp_q.size() == 0, "R10 write seen", exp_q.size(), 0);

      check(pd_bad == 0, "R8 pull-down changes with SCL high", pd_bad, 0);
      tick(10);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule